// File: doc/BRIEF.md
# Profile-Selected DDS Quadrature Modulator

This block is a numerically controlled oscillator followed by a digital quadrature mixer. A 32-bit phase accumulator advances each system clock by a frequency tuning word. The top phase bits address a quarter-wave amplitude table, which yields matching sine and cosine carriers. Four profiles each hold a tuning word, and two select pins pick which profile drives the accumulator.

Each profile has a shadow copy and an active copy. The register port writes only the shadow copy. A frequency-update strobe, which may come from another clock domain, copies every shadow word into its active copy. Moving the select pins switches between active words at once, with no strobe needed.

In modulator mode the output is the rounded and saturated sum of I times cosine and minus Q times sine. In single-tone mode the I and Q inputs are ignored and the cosine carrier is sent straight to the output.

Top module: `dds_quad_mod`

## Requirements
- R1: Each clock that is not a reset clock, the 32-bit accumulator adds the active tuning word of the selected profile, wrapping modulo 2^32.
- R2: With the top 8 accumulator bits taken as phase p (0..255), the sine carrier equals round(8191·sin(2π(p+0.5)/256)) and the cosine carrier equals the same expression at p+64 (mod 256). Rounding goes half away from zero.
- R3: A register write (wr_en high, wr_idx choosing profile 0..3, wr_word holding the value) changes only that profile's shadow word. The accumulator step stays the same until an update load.
- R4: The update strobe passes through two synchronising flops and is edge-detected. A rise of the strobe copies all four shadow words to their active copies on the third rising clock edge that samples it high. A strobe held high loads exactly once.
- R5: Changing prof_sel makes that profile's active word the step used from the next clock edge, with no strobe.
- R6: In modulator mode (tone_mode = 0), the output is (I·cos − Q·sin + 4096) shifted arithmetically right by 13. I, Q and the output are 14-bit two's complement. The result is saturated to the range −8192..8191.
- R7: In single-tone mode (tone_mode = 1), the output equals the cosine carrier, and I and Q have no effect.
- R8: Timing from accumulator to output: the carriers register the accumulator value from the previous edge. The output register combines those carriers with the I, Q and tone_mode values present at its own edge.
- R9: A synchronous active-high reset clears the accumulator, all shadow and active words, the carriers, the strobe synchroniser and the output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Shadow word write enable |
| wr_idx | input | 2 | Profile written |
| wr_word | input | 32 | Tuning word written |
| upd_strobe | input | 1 | Frequency-update strobe, asynchronous |
| prof_sel | input | 2 | Active profile select |
| tone_mode | input | 1 | 0 = modulator, 1 = single tone |
| i_in | input | 14 | In-phase sample, two's complement |
| q_in | input | 14 | Quadrature sample, two's complement |
| dout | output | 14 | Output sample, two's complement |

## Verification
The assertions take for granted that prof_sel, tone_mode, I and Q are synchronous to clk. They also assume that a strobe high period is wide enough for the synchroniser to see it, and that reset is asserted from time zero.

The bench changes every input only on the falling edge, so each value is present across a whole rising edge. Its strobe pulses last at least one full clock period. A lockstep reference model, built from the requirement formulas, follows every cycle after reset release.

// File: rtl/dds_qmod_pkg.sv
package dds_qmod_pkg;

    localparam int AMP_W = 14;

    typedef enum logic {
        OUT_MIXED = 1'b0,
        OUT_TONE  = 1'b1
    } out_sel_e;

    typedef struct packed {
        logic signed [AMP_W-1:0] sin_v;
        logic signed [AMP_W-1:0] cos_v;
    } carrier_t;

    // Magnitude of one quarter-wave point, sampled at the middle of its bin.
    function automatic logic [AMP_W-1:0] qw_point(input int idx, input int qpts);
        real ang;
        real val;
        ang = 2.0 * 3.14159265358979 * (real'(idx) + 0.5) / (4.0 * real'(qpts));
        val = real'((1 << (AMP_W - 1)) - 1) * $sin(ang);
        return AMP_W'($rtoi(val + 0.5));
    endfunction

endpackage

// File: rtl/dds_strobe_sync.sv
module dds_strobe_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_in,
    output logic load_o
);

    logic [SYNC_STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-1:0], strobe_in};
        end
    end

    assign load_o = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

endmodule

// File: rtl/dds_profile_bank.sv
module dds_profile_bank #(
    parameter int ACC_W  = 32,
    parameter int N_PROF = 4,
    parameter int SEL_W  = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [SEL_W-1:0]          wr_idx,
    input  logic [ACC_W-1:0]          wr_word,
    input  logic                      load,
    input  logic [SEL_W-1:0]          sel,
    output logic [ACC_W-1:0]          act_word,
    output logic [N_PROF*ACC_W-1:0]   act_flat
);

    for (genvar p = 0; p < N_PROF; p++) begin : g_prof
        logic [ACC_W-1:0] shadow_q;
        logic [ACC_W-1:0] active_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                shadow_q <= '0;
                active_q <= '0;
            end else begin
                if (wr_en && (wr_idx == SEL_W'(p))) begin
                    shadow_q <= wr_word;
                end
                if (load) begin
                    active_q <= shadow_q;
                end
            end
        end

        assign act_flat[p*ACC_W +: ACC_W] = active_q;
    end

    always_comb begin
        act_word = '0;
        for (int k = 0; k < N_PROF; k++) begin
            if (sel == SEL_W'(k)) begin
                act_word = act_flat[k*ACC_W +: ACC_W];
            end
        end
    end

endmodule

// File: rtl/dds_phase_gen.sv
module dds_phase_gen
    import dds_qmod_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int PH_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] step,
    output carrier_t         carrier_o
);

    localparam int IDX_W = PH_W - 2;
    localparam int QPTS  = 1 << IDX_W;

    logic [ACC_W-1:0]        acc_q;
    logic [QPTS*AMP_W-1:0]   tbl_flat;
    logic [PH_W-1:0]         ph_s, ph_c;
    logic [IDX_W-1:0]        idx_s, idx_c;
    logic [AMP_W-1:0]        mag_s, mag_c;
    carrier_t                car_n, car_q;

    for (genvar g = 0; g < QPTS; g++) begin : g_tbl
        localparam logic [AMP_W-1:0] ENT = qw_point(g, QPTS);
        assign tbl_flat[g*AMP_W +: AMP_W] = ENT;
    end

    always_comb begin
        ph_s  = acc_q[ACC_W-1 -: PH_W];
        ph_c  = ph_s + PH_W'(QPTS);
        idx_s = ph_s[PH_W-2] ? ~ph_s[IDX_W-1:0] : ph_s[IDX_W-1:0];
        idx_c = ph_c[PH_W-2] ? ~ph_c[IDX_W-1:0] : ph_c[IDX_W-1:0];
        mag_s = tbl_flat[int'(idx_s)*AMP_W +: AMP_W];
        mag_c = tbl_flat[int'(idx_c)*AMP_W +: AMP_W];
        car_n.sin_v = ph_s[PH_W-1] ? -$signed(mag_s) : $signed(mag_s);
        car_n.cos_v = ph_c[PH_W-1] ? -$signed(mag_c) : $signed(mag_c);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            car_q <= '0;
        end else begin
            acc_q <= acc_q + step;
            car_q <= car_n;
        end
    end

    assign carrier_o = car_q;

endmodule

// File: rtl/dds_out_stage.sv
module dds_out_stage
    import dds_qmod_pkg::*;
#(
    parameter int DAT_W = 14
) (
    input  logic                    clk,
    input  logic                    rst,
    input  out_sel_e                mode,
    input  carrier_t                carrier,
    input  logic signed [DAT_W-1:0] i_s,
    input  logic signed [DAT_W-1:0] q_s,
    output logic signed [DAT_W-1:0] dout_o
);

    localparam int PRD_W = DAT_W + AMP_W;
    localparam int SUM_W = PRD_W + 1;
    localparam logic signed [SUM_W-1:0] HALF_LSB = SUM_W'(1) <<< (AMP_W - 2);
    localparam logic signed [SUM_W-1:0] MAX_V    = SUM_W'((1 << (DAT_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] MIN_V    = -MAX_V - SUM_W'(1);

    logic signed [PRD_W-1:0] p_i, p_q;
    logic signed [SUM_W-1:0] diff, scaled;
    logic signed [DAT_W-1:0] mixed, next_out;

    always_comb begin
        p_i    = i_s * carrier.cos_v;
        p_q    = q_s * carrier.sin_v;
        diff   = SUM_W'(p_i) - SUM_W'(p_q);
        scaled = (diff + HALF_LSB) >>> (AMP_W - 1);
        if (scaled > MAX_V) begin
            mixed = MAX_V[DAT_W-1:0];
        end else if (scaled < MIN_V) begin
            mixed = MIN_V[DAT_W-1:0];
        end else begin
            mixed = scaled[DAT_W-1:0];
        end
        next_out = (mode == OUT_TONE) ? DAT_W'(carrier.cos_v) : mixed;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_o <= '0;
        end else begin
            dout_o <= next_out;
        end
    end

endmodule

// File: rtl/dds_quad_mod.sv
module dds_quad_mod
    import dds_qmod_pkg::*;
#(
    parameter  int ACC_W       = 32,
    parameter  int PH_W        = 8,
    parameter  int N_PROF      = 4,
    parameter  int DAT_W       = 14,
    parameter  int SYNC_STAGES = 2,
    localparam int SEL_W       = $clog2(N_PROF)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_idx,
    input  logic [ACC_W-1:0] wr_word,
    input  logic             upd_strobe,
    input  logic [SEL_W-1:0] prof_sel,
    input  logic             tone_mode,
    input  logic [DAT_W-1:0] i_in,
    input  logic [DAT_W-1:0] q_in,
    output logic [DAT_W-1:0] dout
);

    logic                       load_p;
    logic [ACC_W-1:0]           step_w;
    logic [N_PROF*ACC_W-1:0]    act_flat;
    carrier_t                   car_w;
    logic signed [AMP_W-1:0]    cos_w, sin_w;
    logic signed [DAT_W-1:0]    out_w;
    out_sel_e                   mode_w;

    assign mode_w = out_sel_e'(tone_mode);
    assign cos_w  = car_w.cos_v;
    assign sin_w  = car_w.sin_v;

    dds_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst       (rst),
        .strobe_in (upd_strobe),
        .load_o    (load_p)
    );

    dds_profile_bank #(.ACC_W(ACC_W), .N_PROF(N_PROF), .SEL_W(SEL_W)) bank_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_word  (wr_word),
        .load     (load_p),
        .sel      (prof_sel),
        .act_word (step_w),
        .act_flat (act_flat)
    );

    dds_phase_gen #(.ACC_W(ACC_W), .PH_W(PH_W)) nco_i (
        .clk       (clk),
        .rst       (rst),
        .step      (step_w),
        .carrier_o (car_w)
    );

    dds_out_stage #(.DAT_W(DAT_W)) mix_i (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode_w),
        .carrier (car_w),
        .i_s     ($signed(i_in)),
        .q_s     ($signed(q_in)),
        .dout_o  (out_w)
    );

    assign dout = out_w;

endmodule

// File: rtl/dds_quad_mod_chk.sv
module dds_quad_mod_chk
    import dds_qmod_pkg::*;
#(
    parameter int ACC_W  = 32,
    parameter int N_PROF = 4,
    parameter int DAT_W  = 14
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    load_p,
    input logic [N_PROF*ACC_W-1:0] act_flat,
    input logic                    tone_mode,
    input logic [DAT_W-1:0]        i_in,
    input logic [DAT_W-1:0]        q_in,
    input logic signed [AMP_W-1:0] cos_w,
    input logic signed [AMP_W-1:0] sin_w,
    input logic [DAT_W-1:0]        dout
);

    // R3
    active_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load_p |=> $stable(act_flat));

    // R4
    single_load_chk: assert property (@(posedge clk) disable iff (rst)
        load_p |=> !load_p);

    // R7
    tone_pass_chk: assert property (@(posedge clk) disable iff (rst)
        tone_mode |=> (dout == DAT_W'($past(cos_w))));

    // R6
    zero_mix_chk: assert property (@(posedge clk) disable iff (rst)
        (!tone_mode && i_in == '0 && q_in == '0) |=> (dout == '0));

    // R2
    carrier_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (cos_w != '0 && sin_w != '0));

endmodule

bind dds_quad_mod dds_quad_mod_chk #(
    .ACC_W  (ACC_W),
    .N_PROF (N_PROF),
    .DAT_W  (DAT_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .load_p    (load_p),
    .act_flat  (act_flat),
    .tone_mode (tone_mode),
    .i_in      (i_in),
    .q_in      (q_in),
    .cos_w     (cos_w),
    .sin_w     (sin_w),
    .dout      (dout)
);

// File: tb/dds_quad_mod_tb_top.sv
`timescale 1ns/1ps
module dds_quad_mod_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic [31:0] wr_word = '0;
    logic        upd_strobe = 1'b0;
    logic [1:0]  prof_sel = '0;
    logic        tone_mode = 1'b0;
    logic [13:0] i_in = '0;
    logic [13:0] q_in = '0;
    logic [13:0] dout;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    trk = 1'b0;
    string cur_req = "R9";

    always #4 clk = ~clk;

    dds_quad_mod dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_word(wr_word),
        .upd_strobe(upd_strobe), .prof_sel(prof_sel), .tone_mode(tone_mode),
        .i_in(i_in), .q_in(q_in), .dout(dout)
    );

    // Reference carrier, evaluated over the full circle (R2).
    function automatic int ref_sin(input int p);
        real a;
        real v;
        a = 2.0 * 3.14159265358979 * (real'(p % 256) + 0.5) / 256.0;
        v = 8191.0 * $sin(a);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(-v + 0.5);
    endfunction

    // Lockstep model built from the requirements.
    logic [31:0] m_shadow [4];
    logic [31:0] m_active [4];
    logic        m_s1, m_s2, m_s3;
    logic [31:0] m_acc;
    int          m_cos, m_sin, m_out;

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 4; k++) begin
                m_shadow[k] <= '0;
                m_active[k] <= '0;
            end
            m_s1 <= 1'b0; m_s2 <= 1'b0; m_s3 <= 1'b0;
            m_acc <= '0; m_cos <= 0; m_sin <= 0; m_out <= 0;
        end else begin
            longint x;
            longint r;
            if (wr_en) m_shadow[wr_idx] <= wr_word;
            if (m_s2 && !m_s3) begin
                for (int k = 0; k < 4; k++) m_active[k] <= m_shadow[k];
            end
            m_s1 <= upd_strobe; m_s2 <= m_s1; m_s3 <= m_s2;
            m_acc <= m_acc + m_active[prof_sel];
            m_sin <= ref_sin(int'(m_acc[31:24]));
            m_cos <= ref_sin(int'(m_acc[31:24]) + 64);
            x = longint'($signed(i_in)) * m_cos - longint'($signed(q_in)) * m_sin;
            r = (x + 4096) >>> 13;
            if (r > 8191) r = 8191;
            if (r < -8192) r = -8192;
            m_out <= tone_mode ? m_cos : int'(r);
        end
    end

    task automatic chk(input string req, input int exp);
        int got;
        got = int'($signed(dout));
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: dout=%0d expected=%0d at %0t", req, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (trk) chk(cur_req, m_out);
    end

    task automatic write_word(input int idx, input logic [31:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 2'(idx); wr_word = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_strobe(input int len);
        @(negedge clk);
        upd_strobe = 1'b1;
        repeat (len) @(negedge clk);
        upd_strobe = 1'b0;
    endtask

    typedef struct packed {
        logic        tone;
        logic [1:0]  ps;
        logic [13:0] iv;
        logic [13:0] qv;
        logic [7:0]  len;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 2'd0, 14'd4000,  14'd0,     8'd20},
        '{1'b0, 2'd1, 14'd0,     14'd3000,  8'd20},
        '{1'b0, 2'd2, 14'h3000,  14'd1500,  8'd20},
        '{1'b1, 2'd1, 14'd8191,  14'h2000,  8'd20},
        '{1'b0, 2'd3, 14'd8191,  14'h2000,  8'd16},
        '{1'b1, 2'd2, 14'd123,   14'd77,    8'd20},
        '{1'b0, 2'd0, 14'h2000,  14'h2000,  8'd16},
        '{1'b1, 2'd3, 14'h1555,  14'h2AAA,  8'd12}
    };

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        i_in = 14'd8191; q_in = 14'h2000;
        repeat (3) @(negedge clk);
        chk("R9 reset output", 0);
        rst = 1'b0;
        trk = 1'b1;
        cur_req = "R6";
        repeat (3) @(negedge clk);
        chk("R6 positive saturation", 8191);
        i_in = 14'h2000; q_in = 14'd8191;
        @(negedge clk);
        chk("R6 negative saturation", -8192);
        i_in = '0; q_in = '0;
        @(negedge clk);
        chk("R6 zero input", 0);
        tone_mode = 1'b1; i_in = 14'd1234; q_in = 14'h3FB3;
        cur_req = "R7";
        @(negedge clk);
        chk("R7 tone at phase 0", 8190);

        // Shadow write without strobe leaves the step at zero.
        cur_req = "R3";
        write_word(0, 32'h0100_0000);
        repeat (8) begin
            @(negedge clk);
            chk("R3 no load before strobe", 8190);
        end

        // Strobe: load occurs on the third edge; then full-circle sweep.
        cur_req = "R4";
        pulse_strobe(1);
        repeat (6) @(negedge clk);
        cur_req = "R2";
        repeat (260) @(negedge clk);

        // Long strobe: a write during the high period must not load.
        cur_req = "R4";
        @(negedge clk);
        upd_strobe = 1'b1;
        repeat (5) @(negedge clk);
        wr_en = 1'b1; wr_idx = 2'd0; wr_word = 32'h0300_0000;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (10) @(negedge clk);
        upd_strobe = 1'b0;
        repeat (10) @(negedge clk);

        // Other profiles, then immediate switching.
        cur_req = "R5";
        write_word(1, 32'h0234_5678);
        write_word(2, 32'hFFFF_0000);
        write_word(3, 32'h4000_0000);
        pulse_strobe(2);
        repeat (5) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            prof_sel = 2'(k % 4);
            repeat (3) @(negedge clk);
        end

        // Accumulator wrap with a near-full-scale step.
        cur_req = "R1";
        write_word(2, 32'hFEFF_FFFF);
        pulse_strobe(1);
        prof_sel = 2'd2;
        repeat (40) @(negedge clk);

        // Table walk.
        for (int v = 0; v < 8; v++) begin
            tone_mode = VECS[v].tone;
            prof_sel  = VECS[v].ps;
            i_in      = VECS[v].iv;
            q_in      = VECS[v].qv;
            cur_req   = VECS[v].tone ? "R7" : "R6";
            repeat (int'(VECS[v].len)) @(negedge clk);
        end

        // Single-cycle input step is seen on the next output.
        cur_req = "R8";
        tone_mode = 1'b0;
        i_in = '0; q_in = '0;
        repeat (3) @(negedge clk);
        i_in = 14'd5000;
        repeat (4) @(negedge clk);

        // Reset mid-run clears all profile words.
        cur_req = "R9";
        rst = 1'b1;
        @(negedge clk);
        chk("R9 output cleared", 0);
        rst = 1'b0;
        tone_mode = 1'b1;
        repeat (3) @(negedge clk);
        repeat (6) begin
            @(negedge clk);
            chk("R9 profiles cleared", 8190);
        end

        trk = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule